// File: doc/BRIEF.md
# SMRAM Access Control Decoder

This block sits in the request path of a memory controller. For every bus request it decides whether the access is served by the protected system-management RAM or by ordinary system memory. A request may also be rejected. The decision depends on four things: the address, which master issued the request, whether the processor is currently in its management mode, and three control bits that boot firmware programs.

The decoder first captures the request in a register. A purely combinational route stage then works on the captured request, so the outcome appears one clock after the request is presented. During boot, firmware can open the protected window to ordinary processor accesses, so that the management handler can be installed before the first management interrupt. A sticky lock bit then stops the window from being reopened until reset.

Inside management mode, a bypass bit sends the handler's data accesses to the ordinary memory that lies under the protected window. Instruction fetches keep running from protected RAM. Masters other than the processor can never reach protected RAM. By default their window accesses are quietly redirected to ordinary memory. A build-time option rejects them instead.

Top module: `smram_decoder`

## Requirements
- R1: After reset the control bits open, lock and bypass are all clear and every output is low, so a processor access to the window outside management mode selects main memory.
- R2: A valid request whose address lies outside the protected window asserts only sel_main_o, whatever the requester, mode or control bits.
- R3: A valid request from a non-CPU master (req_cpu_i = 0) inside the window never asserts sel_smram_o. With NONCPU_ABORT = 0 it asserts sel_main_o; with NONCPU_ABORT = 1 it asserts deny_o.
- R4: A valid CPU request inside the window while smm_active_i = 1 and bypass is clear asserts sel_smram_o.
- R5: Outside management mode, a CPU request inside the window asserts sel_smram_o when the open bit is set and sel_main_o when it is clear.
- R6: In management mode with bypass set, a CPU data access (req_fetch_i = 0) inside the window asserts sel_main_o, while an instruction fetch (req_fetch_i = 1) asserts sel_smram_o.
- R7: Writing cfg_lock_i = 1 sets a lock that only reset clears. While it is set, a write cannot set the open bit, although it can still clear it.
- R8: Outputs reflect the request sampled at the previous rising clock edge. For a valid request exactly one of sel_smram_o, sel_main_o and deny_o is high; for an idle cycle all three are low.
- R9: The window spans WIN_BASE to WIN_BASE + WIN_SIZE - 1 inclusive, by default 0x38000 through 0x3FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_cpu_i | input | 1 | 1 when the requester is the processor |
| req_fetch_i | input | 1 | 1 for an instruction fetch, 0 for a data access |
| smm_active_i | input | 1 | Processor management-mode status |
| cfg_we_i | input | 1 | Control-bit write strobe |
| cfg_open_i | input | 1 | Requested value of the open bit |
| cfg_lock_i | input | 1 | Sets the sticky lock when 1 |
| cfg_bypass_i | input | 1 | Requested value of the bypass bit |
| sel_smram_o | output | 1 | Route to protected RAM |
| sel_main_o | output | 1 | Route to main memory |
| deny_o | output | 1 | Request rejected |

## Verification
The bench builds two instances with ADDR_W = 20 and the default window: one with NONCPU_ABORT = 0 and one with NONCPU_ABORT = 1. Twenty address bits keep the sweep small. For every combination of open and bypass bits, the bench sweeps every mix of requester, mode and access kind. Each mix is run against addresses just below, at, inside, at the top of and just above the window, plus an address far away. The two instances give both policies for foreign masters in one run. Separate sequences cover the lock, including its effect on an already open window, and show that only reset clears it.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_SMRAM = 2'd1,
    ROUTE_MAIN  = 2'd2,
    ROUTE_DENY  = 2'd3
  } route_e;

  typedef struct packed {
    logic open;
    logic lock;
    logic bypass;
  } cfg_t;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic open_i,
  input  logic lock_i,
  input  logic bypass_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      // locked: open may only fall
      cfg_d.open   = cfg_q.lock ? (cfg_q.open & open_i) : open_i;
      cfg_d.lock   = cfg_q.lock | lock_i;
      cfg_d.bypass = bypass_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> cfg_q.lock);
  a_r7_open_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.lock && !cfg_q.open) |=> !cfg_q.open);
endmodule

// File: rtl/smram_req_reg.sv
module smram_req_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_i,
  input  logic              fetch_i,
  input  logic              smm_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cpu_o,
  output logic              fetch_o,
  output logic              smm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      cpu_o   <= 1'b0;
      fetch_o <= 1'b0;
      smm_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      addr_o  <= addr_i;
      cpu_o   <= cpu_i;
      fetch_o <= fetch_i;
      smm_o   <= smm_i;
    end
  end
endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter logic [63:0] WIN_BASE     = 64'h38000,
  parameter logic [63:0] WIN_SIZE     = 64'h8000,
  parameter bit          NONCPU_ABORT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_i,
  input  logic              fetch_i,
  input  logic              smm_i,
  input  cfg_t              cfg_i,
  output route_e            route_o
);
  localparam logic [ADDR_W-1:0] BASE = WIN_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WIN_BASE + WIN_SIZE - 64'd1);

  logic   in_win;
  route_e foreign_route;

  assign in_win = (addr_i >= BASE) && (addr_i <= LAST);

  generate
    if (NONCPU_ABORT) begin : g_abort
      assign foreign_route = ROUTE_DENY;
    end else begin : g_redirect
      assign foreign_route = ROUTE_MAIN;
    end
  endgenerate

  always_comb begin
    if (!valid_i)      route_o = ROUTE_NONE;
    else if (!in_win)  route_o = ROUTE_MAIN;
    else if (!cpu_i)   route_o = foreign_route;
    else if (smm_i)    route_o = (cfg_i.bypass && !fetch_i) ? ROUTE_MAIN : ROUTE_SMRAM;
    else               route_o = cfg_i.open ? ROUTE_SMRAM : ROUTE_MAIN;
  end

  a_r3_foreign_never_smram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cpu_i) |-> (route_o != ROUTE_SMRAM));
  a_r8_idle_no_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (route_o == ROUTE_NONE));
  a_r6_fetch_stays_smram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cpu_i && smm_i && fetch_i && in_win) |-> (route_o == ROUTE_SMRAM));
endmodule

// File: rtl/smram_decoder.sv
module smram_decoder
  import smram_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter logic [63:0] WIN_BASE     = 64'h38000,
  parameter logic [63:0] WIN_SIZE     = 64'h8000,
  parameter bit          NONCPU_ABORT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_cpu_i,
  input  logic              req_fetch_i,
  input  logic              smm_active_i,
  input  logic              cfg_we_i,
  input  logic              cfg_open_i,
  input  logic              cfg_lock_i,
  input  logic              cfg_bypass_i,
  output logic              sel_smram_o,
  output logic              sel_main_o,
  output logic              deny_o
);
  cfg_t              cfg;
  logic              r_valid, r_cpu, r_fetch, r_smm;
  logic [ADDR_W-1:0] r_addr;
  route_e            route;

  smram_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .open_i(cfg_open_i), .lock_i(cfg_lock_i),
    .bypass_i(cfg_bypass_i), .cfg_o(cfg)
  );

  smram_req_reg #(.ADDR_W(ADDR_W)) u_req (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i), .addr_i(req_addr_i), .cpu_i(req_cpu_i),
    .fetch_i(req_fetch_i), .smm_i(smm_active_i),
    .valid_o(r_valid), .addr_o(r_addr), .cpu_o(r_cpu),
    .fetch_o(r_fetch), .smm_o(r_smm)
  );

  smram_route #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
    .NONCPU_ABORT(NONCPU_ABORT)
  ) u_route (
    .clk_i, .rst_ni,
    .valid_i(r_valid), .addr_i(r_addr), .cpu_i(r_cpu), .fetch_i(r_fetch),
    .smm_i(r_smm), .cfg_i(cfg), .route_o(route)
  );

  assign sel_smram_o = (route == ROUTE_SMRAM);
  assign sel_main_o  = (route == ROUTE_MAIN);
  assign deny_o      = (route == ROUTE_DENY);

  a_r8_one_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_smram_o, sel_main_o, deny_o}));
  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> $countones({sel_smram_o, sel_main_o, deny_o}) == 1);
  a_r3_foreign_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_cpu_i) |=> !sel_smram_o);
endmodule

// File: tb/sim_smram_decoder.sv
module sim_smram_decoder;
  localparam int  CLK_PERIOD = 10;
  localparam int  AW = 20;
  localparam logic [AW-1:0] WB = 20'h38000;
  localparam logic [AW-1:0] WL = 20'h3FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, cpu = 0, fetch = 0, smm = 0;
  logic [AW-1:0] addr = '0;
  logic we = 0, c_open = 0, c_lock = 0, c_byp = 0;
  logic s0, m0, d0, s1, m1, d1;
  int tests = 0, fails = 0;
  logic exp_open = 0, exp_byp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_decoder #(.ADDR_W(AW), .NONCPU_ABORT(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
    .req_cpu_i(cpu), .req_fetch_i(fetch), .smm_active_i(smm),
    .cfg_we_i(we), .cfg_open_i(c_open), .cfg_lock_i(c_lock), .cfg_bypass_i(c_byp),
    .sel_smram_o(s0), .sel_main_o(m0), .deny_o(d0));

  smram_decoder #(.ADDR_W(AW), .NONCPU_ABORT(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
    .req_cpu_i(cpu), .req_fetch_i(fetch), .smm_active_i(smm),
    .cfg_we_i(we), .cfg_open_i(c_open), .cfg_lock_i(c_lock), .cfg_bypass_i(c_byp),
    .sel_smram_o(s1), .sel_main_o(m1), .deny_o(d1));

  // returns {smram, main, deny}
  function automatic logic [2:0] model(bit abort, logic v, logic [AW-1:0] a,
      logic c, logic sm, logic f, logic op, logic by);
    if (!v) return 3'b000;
    if (a < WB || a > WL) return 3'b010;            // R2, R9
    if (!c) return abort ? 3'b001 : 3'b010;         // R3
    if (sm) return (by && !f) ? 3'b010 : 3'b100;    // R4, R6
    return op ? 3'b100 : 3'b010;                    // R5
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (addr=%h cpu=%b smm=%b fetch=%b)",
               req, act, exp, addr, cpu, smm, fetch);
    end
  endtask

  task automatic cfg_write(logic op, logic lk, logic by);
    @(negedge clk);
    we = 1; c_open = op; c_lock = lk; c_byp = by;
    @(negedge clk);
    we = 0;
  endtask

  task automatic probe(string req, logic v, logic [AW-1:0] a, logic c, logic sm, logic f);
    @(negedge clk);
    valid = v; addr = a; cpu = c; smm = sm; fetch = f;
    @(negedge clk);
    check(req, {s0, m0, d0}, model(1'b0, v, a, c, sm, f, exp_open, exp_byp));
    check(req, {s1, m1, d1}, model(1'b1, v, a, c, sm, f, exp_open, exp_byp));
    valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_open = 0; exp_byp = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [6];
    addrs[0] = 20'h37FFF; addrs[1] = 20'h38000; addrs[2] = 20'h3C123;
    addrs[3] = 20'h3FFFF; addrs[4] = 20'h40000; addrs[5] = 20'h00400;

    do_reset();
    check("R1 reset outputs", {s0, m0, d0}, 3'b000);
    probe("R1 reset cfg", 1, 20'h38000, 1, 0, 0);
    probe("R8 idle", 0, 20'h38000, 1, 1, 0);

    // R2 R3 R4 R5 R6 R8 R9 sweep
    for (int op = 0; op < 2; op++) begin
      for (int by = 0; by < 2; by++) begin
        cfg_write(op[0], 1'b0, by[0]);
        exp_open = op[0]; exp_byp = by[0];
        for (int k = 0; k < 8; k++)
          for (int ai = 0; ai < 6; ai++)
            probe("R2-R9 sweep", 1, addrs[ai], k[0], k[1], k[2]);
      end
    end

    // R7 lock blocks later open
    do_reset();
    cfg_write(1'b0, 1'b1, 1'b0);
    cfg_write(1'b1, 1'b0, 1'b0);
    probe("R7 open blocked by lock", 1, 20'h38000, 1, 0, 0);
    // R7 lock persists, clear then reopen attempt
    do_reset();
    cfg_write(1'b1, 1'b1, 1'b0);
    exp_open = 1;
    probe("R7 open before lock kept", 1, 20'h39000, 1, 0, 1);
    cfg_write(1'b0, 1'b0, 1'b0);
    exp_open = 0;
    probe("R7 clear allowed", 1, 20'h39000, 1, 0, 1);
    cfg_write(1'b1, 1'b0, 1'b0);
    probe("R7 reopen blocked", 1, 20'h39000, 1, 0, 1);
    // R7 reset clears lock
    do_reset();
    cfg_write(1'b1, 1'b0, 1'b0);
    exp_open = 1;
    probe("R7 reset clears lock", 1, 20'h3FFFF, 1, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule